// File: doc/BRIEF.md
# Warp Scoreboard and Issue Stage

This block sits between instruction decode and the execution pipelines of a multi-warp processor core. Decoded instructions arrive one at a time, each tagged with the warp it belongs to. Each instruction also carries one destination register number and two source register numbers. The block keeps a short queue of these instructions for every warp. It also keeps a register-busy table for every warp. Each cycle it chooses at most one instruction to send downstream.

An instruction leaves only when all of the following hold:
- It is the oldest instruction its warp holds.
- None of its registers is still awaited by an earlier instruction of the same warp.
- Its warp is not parked at a barrier.
- The downstream pipeline is not stalled.

When an instruction issues, its destination register is marked busy. A writeback event clears that mark. This lets one warp keep several independent instructions in flight. The busy tables of different warps never affect each other. Each warp also raises a fetch request whenever its queue has drained.

The block has no state machine. Its only sequential state is:
- the per-warp queues,
- the per-warp busy tables,
- a round-robin pointer,
- the registered issue outputs.

Top module: `warp_issue`

## Requirements
- R1: While `rst_n` is low and after it rises, `iss_valid` is 0, every queue is empty, every busy table is clear, and all `fetch_req` bits are 1.
- R2: An instruction accepted at clock edge k issues at edge k+1 at the earliest, through one register stage. At most one instruction issues per cycle.
- R3: `fetch_req[w]` is 1 exactly when warp w holds no buffered instruction.
- R4: Each warp holds up to SLOTS instructions (default 2). An instruction for a warp whose queue is full, and which issues nothing in that cycle, is discarded.
- R5: Within a warp, instructions issue in arrival order. A blocked oldest instruction holds back every younger one of the same warp.
- R6: An instruction does not issue while either of its source registers is busy in its own warp's table (read-after-write).
- R7: An instruction does not issue while its destination register is busy in its own warp's table (write-after-write).
- R8: Issue marks the destination register busy. A `wb_valid` pulse clears register `wb_reg` of warp `wb_wid` only. A writeback naming another warp has no effect.
- R9: A writeback is applied before the hazard check of the same cycle. An instruction waiting only on that register therefore issues at the edge that ends the writeback cycle.
- R10: No instruction of warp w issues at an edge when `bar_wait[w]` was 1 in the cycle before.
- R11: When `stall` is 1 in a cycle, nothing issues at the edge that ends it. Buffered instructions are kept.
- R12: Among eligible warps, the one chosen is the first found when counting upward from the last issuing warp, wrapping around. After reset the search starts at warp 0.
- R13: Independent instructions of one warp issue on consecutive cycles, without waiting for earlier writebacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_wid | input | WID_W | Warp of the incoming instruction |
| in_op | input | OP_W | Opaque operation payload |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| bar_wait | input | NUM_WARPS | Per-warp barrier wait flags |
| stall | input | 1 | Downstream cannot accept an instruction |
| wb_valid | input | 1 | Writeback release event |
| wb_wid | input | WID_W | Warp of the writeback |
| wb_reg | input | REG_W | Register released |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_wid | output | WID_W | Warp of the issued instruction |
| iss_op | output | OP_W | Payload of the issued instruction |
| iss_dst | output | REG_W | Destination of the issued instruction |
| iss_src_a | output | REG_W | First source of the issued instruction |
| iss_src_b | output | REG_W | Second source of the issued instruction |
| fetch_req | output | NUM_WARPS | Per-warp request for new instructions |

## Verification
An accepted instruction can appear on the issue outputs no sooner than one edge after acceptance. Removing a stall, a barrier flag or a busy register produces an issue at the edge that closes the cycle in which the condition cleared. `fetch_req` follows the queue contents with no extra delay. The bench drives on falling edges and reads outputs on the falling edge that follows each predicted rising edge, so every expected event is checked in its exact cycle. A queue of expected warp and payload pairs then confirms the overall issue order, including round-robin order and in-warp program order.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
    parameter int OP_W  = 8;
    parameter int NREG  = 16;
    localparam int REG_W = $clog2(NREG);

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] sa;
        logic [REG_W-1:0] sb;
    } instr_t;
endpackage

// File: rtl/wsi_ibuf.sv
module wsi_ibuf
    import wsi_pkg::*;
#(
    parameter int SLOTS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  instr_t push_ins,
    input  logic   pop,
    output instr_t head,
    output logic   head_vld,
    output logic   empty
);
    logic [SLOTS-1:0] vld_q, nv;
    instr_t           slot_q [SLOTS];
    instr_t           ns     [SLOTS];
    logic             placed;

    always_comb begin
        nv     = vld_q;
        ns     = slot_q;
        placed = 1'b0;
        if (pop) begin
            for (int i = 0; i < SLOTS - 1; i++) begin
                nv[i] = vld_q[i+1];
                ns[i] = slot_q[i+1];
            end
            nv[SLOTS-1] = 1'b0;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (push && !placed && !nv[i]) begin
                ns[i]  = push_ins;
                nv[i]  = 1'b1;
                placed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            slot_q <= '{default: '0};
        end else begin
            vld_q  <= nv;
            slot_q <= ns;
        end
    end

    assign head     = slot_q[0];
    assign head_vld = vld_q[0];
    assign empty    = ~|vld_q;
endmodule

// File: rtl/wsi_sb.sv
module wsi_sb
    import wsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel,
    input  logic [REG_W-1:0] rel_reg,
    input  logic             rsv,
    input  logic [REG_W-1:0] rsv_reg,
    input  instr_t           chk,
    output logic             hazard
);
    logic [NREG-1:0] busy_q, live;

    // release is applied before both the check and the new reservation
    always_comb begin
        live = busy_q;
        if (rel) live[rel_reg] = 1'b0;
    end

    assign hazard = live[chk.sa] | live[chk.sb] | live[chk.dst];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= live;
            if (rsv) busy_q[rsv_reg] <= 1'b1;
        end
    end
endmodule

// File: rtl/wsi_rr.sv
module wsi_rr #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!any && req[c]) begin
                any      = 1'b1;
                idx      = IW'(c);
                grant[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/warp_issue.sv
module warp_issue
    import wsi_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int SLOTS     = 2,
    parameter int WID_W     = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WID_W-1:0]     in_wid,
    input  logic [OP_W-1:0]      in_op,
    input  logic [REG_W-1:0]     in_dst,
    input  logic [REG_W-1:0]     in_src_a,
    input  logic [REG_W-1:0]     in_src_b,
    input  logic [NUM_WARPS-1:0] bar_wait,
    input  logic                 stall,
    input  logic                 wb_valid,
    input  logic [WID_W-1:0]     wb_wid,
    input  logic [REG_W-1:0]     wb_reg,
    output logic                 iss_valid,
    output logic [WID_W-1:0]     iss_wid,
    output logic [OP_W-1:0]      iss_op,
    output logic [REG_W-1:0]     iss_dst,
    output logic [REG_W-1:0]     iss_src_a,
    output logic [REG_W-1:0]     iss_src_b,
    output logic [NUM_WARPS-1:0] fetch_req
);
    instr_t                 in_ins;
    instr_t                 head [NUM_WARPS];
    logic [NUM_WARPS-1:0]   head_vld, hazard, elig, grant, empty;
    logic [WID_W-1:0]       last_q, pick;
    logic                   pick_vld;

    assign in_ins = '{op: in_op, dst: in_dst, sa: in_src_a, sb: in_src_b};

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic push_w, rel_w;
        assign push_w = in_valid && (in_wid == WID_W'(w));
        assign rel_w  = wb_valid && (wb_wid == WID_W'(w));

        wsi_ibuf #(.SLOTS(SLOTS)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_w),
            .push_ins (in_ins),
            .pop      (grant[w]),
            .head     (head[w]),
            .head_vld (head_vld[w]),
            .empty    (empty[w])
        );

        wsi_sb u_sb (
            .clk     (clk),
            .rst_n   (rst_n),
            .rel     (rel_w),
            .rel_reg (wb_reg),
            .rsv     (grant[w]),
            .rsv_reg (head[w].dst),
            .chk     (head[w]),
            .hazard  (hazard[w])
        );

        assign elig[w]      = head_vld[w] && !hazard[w] && !bar_wait[w] && !stall;
        assign fetch_req[w] = empty[w];
    end

    wsi_rr #(.N(NUM_WARPS), .IW(WID_W)) u_rr (
        .req   (elig),
        .last  (last_q),
        .grant (grant),
        .idx   (pick),
        .any   (pick_vld)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= WID_W'(NUM_WARPS - 1);
            iss_valid <= 1'b0;
            iss_wid   <= '0;
            iss_op    <= '0;
            iss_dst   <= '0;
            iss_src_a <= '0;
            iss_src_b <= '0;
        end else begin
            iss_valid <= pick_vld;
            if (pick_vld) begin
                last_q    <= pick;
                iss_wid   <= pick;
                iss_op    <= head[pick].op;
                iss_dst   <= head[pick].dst;
                iss_src_a <= head[pick].sa;
                iss_src_b <= head[pick].sb;
            end
        end
    end
endmodule

// File: rtl/wsi_chk.sv
module wsi_chk
    import wsi_pkg::*;
#(
    parameter int NUM_WARPS = 4,
    parameter int WID_W     = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] bar_wait,
    input logic                 stall,
    input logic                 wb_valid,
    input logic [WID_W-1:0]     wb_wid,
    input logic [REG_W-1:0]     wb_reg,
    input logic                 iss_valid,
    input logic [WID_W-1:0]     iss_wid,
    input logic [REG_W-1:0]     iss_dst,
    input logic [REG_W-1:0]     iss_src_a,
    input logic [REG_W-1:0]     iss_src_b,
    input logic [NUM_WARPS-1:0] fetch_req
);
    logic [NUM_WARPS-1:0] bar_q, fq_q;
    always_ff @(posedge clk) begin
        bar_q <= bar_wait;
        fq_q  <= fetch_req;
    end

    a_r11_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !$past(stall));

    a_r10_barrier_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !bar_q[iss_wid]);

    a_r3_issue_from_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !fq_q[iss_wid]);

    a_r6_r7_no_reg_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && $past(iss_valid) && iss_wid == $past(iss_wid) &&
         !($past(wb_valid) && $past(wb_wid) == iss_wid && $past(wb_reg) == $past(iss_dst)))
        |-> (iss_src_a != $past(iss_dst) && iss_src_b != $past(iss_dst) &&
             iss_dst != $past(iss_dst)));
endmodule

bind warp_issue wsi_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (.*);

// File: tb/warp_issue_bench.sv
`timescale 1ns/1ps
module warp_issue_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_wid = '0;
    logic [7:0] in_op = '0;
    logic [3:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic [3:0] bar_wait = '0;
    logic       stall = 1'b0;
    logic       wb_valid = 1'b0;
    logic [1:0] wb_wid = '0;
    logic [3:0] wb_reg = '0;
    logic       iss_valid;
    logic [1:0] iss_wid;
    logic [7:0] iss_op;
    logic [3:0] iss_dst, iss_src_a, iss_src_b;
    logic [3:0] fetch_req;

    int total = 0;
    int bad   = 0;
    int   q_wid [$];
    int   q_op  [$];
    string q_tag [$];

    always #2.5 clk = ~clk;

    warp_issue u_warp_issue (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_issue(input int w, input int op, input string tag);
        q_wid.push_back(w);
        q_op.push_back(op);
        q_tag.push_back(tag);
    endtask

    task automatic send(input int w, input int op, input int d, input int a, input int b);
        in_valid = 1'b1; in_wid = 2'(w); in_op = 8'(op);
        in_dst = 4'(d); in_src_a = 4'(a); in_src_b = 4'(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wb(input int w, input int r);
        wb_valid = 1'b1; wb_wid = 2'(w); wb_reg = 4'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!iss_valid, tag, iss_valid, 0);
        end
    endtask

    // monitor: pops expected issues in order
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (q_op.size() == 0) begin
                check(1'b0, "R4/R2 unexpected issue", iss_op, 0);
            end else begin
                int ew, eo;
                string et;
                ew = q_wid.pop_front(); eo = q_op.pop_front(); et = q_tag.pop_front();
                check(iss_wid == 2'(ew), {et, " warp"}, iss_wid, ew);
                check(iss_op == 8'(eo), {et, " op"}, iss_op, eo);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!iss_valid, "R1 iss_valid in reset", iss_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!iss_valid, "R1 iss_valid after reset", iss_valid, 0);
        check(fetch_req == 4'hF, "R1 fetch_req after reset", fetch_req, 4'hF);

        // T1: independent pair, warp 0
        expect_issue(0, 8'h01, "R13 first");
        expect_issue(0, 8'h02, "R13 second");
        send(0, 8'h01, 1, 2, 3);
        check(fetch_req[0] == 1'b0, "R3 busy warp no fetch", fetch_req[0], 0);
        send(0, 8'h02, 4, 5, 6);
        check(iss_valid && iss_op == 8'h01, "R2 one-edge latency", iss_op, 8'h01);
        @(negedge clk);
        check(iss_valid && iss_op == 8'h02, "R13 back to back", iss_op, 8'h02);
        check(fetch_req[0] == 1'b1, "R3 drained warp fetch", fetch_req[0], 1);

        // T2: RAW in warp 1
        expect_issue(1, 8'h11, "R6 producer");
        expect_issue(1, 8'h12, "R6 consumer");
        send(1, 8'h11, 7, 1, 2);
        send(1, 8'h12, 8, 7, 3);
        quiet(3, "R6 raw hold");
        wb(0, 7);
        check(!iss_valid, "R8 other-warp release", iss_valid, 0);
        quiet(1, "R8 other-warp release");
        wb(1, 7);
        check(iss_valid && iss_op == 8'h12, "R9 release first", iss_op, 8'h12);

        // T3: WAW in warp 2
        expect_issue(2, 8'h21, "R7 first");
        expect_issue(2, 8'h22, "R7 second");
        send(2, 8'h21, 9, 0, 0);
        send(2, 8'h22, 9, 0, 0);
        quiet(2, "R7 waw hold");
        wb(3, 9);
        check(!iss_valid, "R8 wrong warp no release", iss_valid, 0);
        wb(2, 9);
        check(iss_valid && iss_op == 8'h22, "R9 waw release", iss_op, 8'h22);

        // T4: barrier on warp 3
        bar_wait = 4'b1000;
        expect_issue(3, 8'h31, "R10 after barrier");
        send(3, 8'h31, 1, 2, 3);
        quiet(3, "R10 barrier hold");
        bar_wait = 4'b0000;
        @(negedge clk);
        check(iss_valid && iss_op == 8'h31, "R10 barrier cleared", iss_op, 8'h31);

        // T5: stall, warp 0
        stall = 1'b1;
        expect_issue(0, 8'h41, "R11 after stall");
        send(0, 8'h41, 10, 11, 12);
        quiet(3, "R11 stall hold");
        stall = 1'b0;
        @(negedge clk);
        check(iss_valid && iss_op == 8'h41, "R11 stall released", iss_op, 8'h41);

        // T6: round robin after warp 0 issued last
        stall = 1'b1;
        send(3, 8'h53, 13, 14, 15);
        send(1, 8'h51, 13, 14, 15);
        send(0, 8'h50, 13, 14, 15);
        send(2, 8'h52, 13, 14, 15);
        quiet(1, "R11 stall hold");
        expect_issue(1, 8'h51, "R12 rr 1");
        expect_issue(2, 8'h52, "R12 rr 2");
        expect_issue(3, 8'h53, "R12 rr 3");
        expect_issue(0, 8'h50, "R12 rr 0");
        stall = 1'b0;
        repeat (6) @(negedge clk);
        check(q_op.size() == 0, "R12 all rr issued", q_op.size(), 0);

        // T7: full buffer drops third instruction
        stall = 1'b1;
        send(1, 8'h61, 2, 5, 6);
        send(1, 8'h62, 3, 5, 6);
        send(1, 8'h63, 4, 5, 6);
        expect_issue(1, 8'h61, "R4 slot 0");
        expect_issue(1, 8'h62, "R4 slot 1");
        stall = 1'b0;
        repeat (6) @(negedge clk);
        check(q_op.size() == 0, "R4 kept entries issued", q_op.size(), 0);
        check(fetch_req[1] == 1'b1, "R4 dropped entry absent", fetch_req[1], 1);

        // T8: blocked oldest holds younger
        expect_issue(0, 8'h71, "R5 older");
        expect_issue(0, 8'h72, "R5 younger");
        send(0, 8'h71, 3, 10, 0);
        send(0, 8'h72, 5, 6, 7);
        quiet(3, "R5 younger held");
        wb(0, 10);
        check(iss_valid && iss_op == 8'h71, "R5 older first", iss_op, 8'h71);
        @(negedge clk);
        check(iss_valid && iss_op == 8'h72, "R5 younger next", iss_op, 8'h72);

        repeat (3) @(negedge clk);
        check(q_op.size() == 0, "R2 expected queue drained", q_op.size(), 0);
        check(fetch_req == 4'hF, "R3 all drained", fetch_req, 4'hF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule